// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter. It steps through a fixed cycle of fifteen clock periods. The first three periods are the track window, in which the sampling switch follows the analog input. In each of the remaining twelve periods the block decides one bit of the code. For each bit it presents a trial code to an external DAC, then reads back a single comparator bit that says whether the input is at or above that DAC level. When a cycle finishes, the block latches the finished code into an output register and raises a data-ready flag for the first period of the next cycle.

The code leaves the block on a split three-state bus. The upper byte and the lower nibble each have their own active-low enable. The active-low start input chooses the mode:

- **Free-run:** while start is held low, cycles follow one another with no gap.
- **Triggered:** when start is released, the sequencer finishes the cycle in progress and then halts in the second period. While halted it keeps tracking, holds data-ready high and gates its own advance off. A later low pulse on start, at least one clock wide, restarts it.

Top module: `sar_conv_sequencer`

## Requirements
- R1: While the synchronous active-high reset is applied, the block enters its halted tracking state. In that state data-ready is 0, the track control is 1, the running flag is 0, the trial code is 0 and the result register is cleared, so the enabled bus reads 0.
- R2: In free-run mode, consecutive rising edges of data-ready are exactly 15 clocks apart.
- R3: The track control is 1 in the first three periods of each cycle and 0 in the twelve decision periods, so a free-run cycle has exactly 3 tracking clocks. The hold state occurs only while the sequencer runs.
- R4: In the first decision period, the trial code is 1 in bit 11 and 0 elsewhere (value 0x800). Bits are decided from bit 11 down to bit 0, one per period.
- R5: A bit is kept when the comparator input is 1 (input at or above the trial code). With an ideal comparator, each latched result equals the input value held during tracking.
- R6: The result register changes only at the clock that starts period 1, which is the clock at which data-ready rises. At every other clock it holds its value.
- R7: While running, data-ready is 1 for exactly one clock per cycle, namely period 1.
- R8: Suppose start is high when period 1 ends. Then the sequencer enters period 2 and halts there: the running flag is 0, tracking is 1, and data-ready stays 1 until the restart.
- R9: The start input passes through a two-flop synchronizer. Let start be driven low just after a clock edge while the sequencer is halted. After the second following edge the running flag is still 0, and after the third it is 1.
- R10: A low pulse on start that begins and ends between two rising clock edges is ignored: the sequencer stays halted.
- R11: When the high enable is 0, the upper bus (8 bits) carries result bits 11..4; when it is 1, that bus is high-impedance. The low enable works the same way for the 4-bit lower bus and result bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| startN | input | 1 | Start request, active low, asynchronous to clk |
| cmpHigh | input | 1 | Comparator result: 1 when the input is at or above the trial code |
| hiEnN | input | 1 | Active-low output enable for the upper result byte |
| loEnN | input | 1 | Active-low output enable for the lower result nibble |
| trialCode | output | 12 | Trial code presented to the external DAC |
| trackEn | output | 1 | Sampling switch control: 1 = track, 0 = hold |
| dataReady | output | 1 | Result-valid flag |
| clkRunning | output | 1 | 1 while the sequencer advances, 0 while halted |
| dataHi | output | 8 | Three-state result bits 11..4 |
| dataLo | output | 4 | Three-state result bits 3..0 |

## Verification
The assertions assume that the comparator bit settles within the same period as the trial code it answers. They also assume that the bus enables change only when nothing is being sampled. The bench meets the first assumption with a combinational ideal comparator. It changes the modelled analog input only in a tracking period and moves the enables only while the sequencer is halted. Start is driven on the falling clock edge, except for the deliberate sub-cycle glitch. That glitch sits entirely inside a low clock phase, so it can never be sampled.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  // Widest conversion the strobe struct can address.
  parameter int unsigned MAX_RES_BITS = 16;
  localparam int unsigned IDX_W = $clog2(MAX_RES_BITS);

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic             decide;       // a bit decision happens this period
    logic             latchResult;  // last decision: move code to result
    logic [IDX_W-1:0] bitIdx;       // bit under trial
  } seq_strobe_t;
endpackage

// File: rtl/sar_start_sync.sv
`timescale 1ns/1ps
module sar_start_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic startN,
  output logic startLow
);
  logic [STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[STAGES-2:0], startN};
  end

  assign startLow = ~syncQ[STAGES-1];
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_BITS      = 12,
  parameter int unsigned TRACK_PERIODS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startLow,
  output seq_strobe_t strobe,
  output logic        trackEn,
  output logic        dataReady,
  output logic        clkRunning
);
  localparam int unsigned CYCLE_LEN = TRACK_PERIODS + RES_BITS;
  localparam int unsigned PER_W     = $clog2(CYCLE_LEN + 1);
  localparam logic [PER_W-1:0] LAST_PER  = PER_W'(CYCLE_LEN);
  localparam logic [PER_W-1:0] TRACK_END = PER_W'(TRACK_PERIODS);
  localparam logic [PER_W-1:0] FIRST_PER = PER_W'(1);
  localparam logic [PER_W-1:0] HALT_PER  = PER_W'(2);

  logic [PER_W-1:0] period;
  logic             halted;
  logic             drdyQ;
  logic [PER_W-1:0] idxWide;

  // Period counter, halt gate and data-ready flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      period <= HALT_PER;
      halted <= 1'b1;
      drdyQ  <= 1'b0;
    end else if (halted) begin
      if (startLow) begin
        halted <= 1'b0;
        drdyQ  <= 1'b0;
      end
    end else if (period == LAST_PER) begin
      period <= FIRST_PER;
      drdyQ  <= 1'b1;
    end else if (period == FIRST_PER) begin
      period <= HALT_PER;
      if (startLow) drdyQ  <= 1'b0;
      else          halted <= 1'b1;
    end else begin
      period <= period + FIRST_PER;
    end
  end

  assign idxWide = LAST_PER - period;

  always_comb begin
    strobe             = '0;
    strobe.decide      = !halted && (period > TRACK_END);
    strobe.latchResult = !halted && (period == LAST_PER);
    strobe.bitIdx      = IDX_W'(idxWide);
  end

  assign trackEn    = halted || (period <= TRACK_END);
  assign dataReady  = drdyQ;
  assign clkRunning = !halted;
endmodule

// File: rtl/sar_seq_datapath.sv
`timescale 1ns/1ps
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  seq_strobe_t         strobe,
  input  logic                cmpHigh,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultQ
);
  localparam logic [RES_BITS-1:0] ONE = RES_BITS'(1);

  logic [RES_BITS-1:0] sarQ;
  logic [RES_BITS-1:0] trialBit;
  logic [RES_BITS-1:0] keepCode;

  assign trialBit  = strobe.decide ? (ONE << strobe.bitIdx) : '0;
  assign trialCode = sarQ | trialBit;
  assign keepCode  = cmpHigh ? trialCode : sarQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      sarQ    <= '0;
      resultQ <= '0;
    end else if (strobe.latchResult) begin
      resultQ <= keepCode;
      sarQ    <= '0;
    end else if (strobe.decide) begin
      sarQ <= keepCode;
    end
  end
endmodule

// File: rtl/sar_conv_sequencer.sv
`timescale 1ns/1ps
module sar_conv_sequencer
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_BITS      = 12,
  parameter int unsigned TRACK_PERIODS = 3,
  parameter int unsigned HI_BITS       = 8,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         startN,
  input  logic                         cmpHigh,
  input  logic                         hiEnN,
  input  logic                         loEnN,
  output logic [RES_BITS-1:0]          trialCode,
  output logic                         trackEn,
  output logic                         dataReady,
  output logic                         clkRunning,
  output wire  [HI_BITS-1:0]           dataHi,
  output wire  [RES_BITS-HI_BITS-1:0]  dataLo
);
  localparam int unsigned LO_BITS = RES_BITS - HI_BITS;

  logic                startLow;
  seq_strobe_t         strobe;
  logic [RES_BITS-1:0] resultQ;

  sar_start_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .startN(startN), .startLow(startLow)
  );

  sar_seq_ctrl #(.RES_BITS(RES_BITS), .TRACK_PERIODS(TRACK_PERIODS)) i_ctrl (
    .clk(clk), .rst(rst), .startLow(startLow), .strobe(strobe),
    .trackEn(trackEn), .dataReady(dataReady), .clkRunning(clkRunning)
  );

  sar_seq_datapath #(.RES_BITS(RES_BITS)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .resultQ(resultQ)
  );

  assign dataHi = hiEnN ? {HI_BITS{1'bz}} : resultQ[RES_BITS-1:LO_BITS];
  assign dataLo = loEnN ? {LO_BITS{1'bz}} : resultQ[LO_BITS-1:0];
endmodule

// File: rtl/sar_seq_checker.sv
`timescale 1ns/1ps
module sar_seq_checker #(
  parameter int unsigned RES_BITS = 12,
  parameter int unsigned HI_BITS  = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        trackEn,
  input logic                        dataReady,
  input logic                        clkRunning,
  input logic                        hiEnN,
  input logic                        loEnN,
  input logic [RES_BITS-1:0]         trialCode,
  input logic [RES_BITS-1:0]         resultQ,
  input logic [HI_BITS-1:0]          dataHi,
  input logic [RES_BITS-HI_BITS-1:0] dataLo
);
  localparam int unsigned LO_BITS = RES_BITS - HI_BITS;
  localparam logic [RES_BITS-1:0] MSB_TRIAL = {1'b1, {(RES_BITS-1){1'b0}}};

  assert_hold_only_running_R3: assert property (@(posedge clk) disable iff (rst)
    !trackEn |-> clkRunning);

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(trackEn) |-> trialCode == MSB_TRIAL);

  assert_result_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !$rose(dataReady) |-> $stable(resultQ));

  assert_drdy_one_period_R7: assert property (@(posedge clk) disable iff (rst)
    (clkRunning && dataReady) |=> (!dataReady || !clkRunning));

  assert_halt_keeps_drdy_R8: assert property (@(posedge clk) disable iff (rst)
    (!clkRunning && $past(!clkRunning)) |-> $stable(dataReady));

  assert_bus_hi_R11: assert property (@(posedge clk) disable iff (rst)
    !hiEnN |-> dataHi == resultQ[RES_BITS-1:LO_BITS]);

  assert_bus_lo_R11: assert property (@(posedge clk) disable iff (rst)
    !loEnN |-> dataLo == resultQ[LO_BITS-1:0]);
endmodule

bind sar_conv_sequencer sar_seq_checker #(.RES_BITS(RES_BITS), .HI_BITS(HI_BITS)) i_chk (
  .clk(clk), .rst(rst), .trackEn(trackEn), .dataReady(dataReady),
  .clkRunning(clkRunning), .hiEnN(hiEnN), .loEnN(loEnN),
  .trialCode(trialCode), .resultQ(resultQ), .dataHi(dataHi), .dataLo(dataLo)
);

// File: tb/test_sar_conv_sequencer.sv
`timescale 1ns/1ps
module test_sar_conv_sequencer;
  localparam int RES = 12;
  localparam int HI  = 8;
  localparam int LO  = 4;
  localparam int NCODES = 1 << RES;

  logic clk = 1'b0, rst = 1'b1, startN = 1'b1;
  logic hiEnN = 1'b0, loEnN = 1'b0, pullVal = 1'b0;
  logic [RES-1:0] vin = '0;
  wire  [RES-1:0] trialCode;
  wire  trackEn, dataReady, clkRunning, cmpHigh;
  wire  [HI-1:0] dataHi;
  wire  [LO-1:0] dataLo;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Ideal comparator model.
  assign cmpHigh = (vin >= trialCode);
  // Weak keepers expose a released bus.
  assign (weak0, weak1) dataHi = pullVal ? {HI{1'b1}} : {HI{1'b0}};
  assign (weak0, weak1) dataLo = pullVal ? {LO{1'b1}} : {LO{1'b0}};

  always #2.5 clk = ~clk;

  sar_conv_sequencer i_sar_conv_sequencer (
    .clk(clk), .rst(rst), .startN(startN), .cmpHigh(cmpHigh),
    .hiEnN(hiEnN), .loEnN(loEnN), .trialCode(trialCode), .trackEn(trackEn),
    .dataReady(dataReady), .clkRunning(clkRunning), .dataHi(dataHi), .dataLo(dataLo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [RES-1:0] codeAt(input int i);
    return RES'((i * 1597) % NCODES);
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      finishRun();
    end
  end

  initial begin
    int sinceRise, trackCnt, drdyCnt, checked, nextIdx;
    bit fullWin, prevDrdy, prevTrack, gotRise;
    logic [RES-1:0] expVin, latched, res;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dataReady", dataReady, 0);
    check("R1 trackEn", trackEn, 1);
    check("R1 clkRunning", clkRunning, 0);
    check("R1 trialCode", trialCode, 0);
    check("R1 result", {dataHi, dataLo}, 0);

    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 idle halted", clkRunning, 0);
    check("R8 idle tracking", trackEn, 1);

    // R10 glitch inside one low clock phase
    #0.5 startN = 1'b0;
    #1   startN = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 glitch ignored", clkRunning, 0);

    // R9 restart latency, then free-run
    vin = codeAt(0);
    expVin = vin;
    startN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 still halted after two edges", clkRunning, 0);
    @(negedge clk);
    check("R9 running after three edges", clkRunning, 1);

    sinceRise = 0; trackCnt = 0; drdyCnt = 0; checked = 0; nextIdx = 1;
    fullWin = 1'b0; prevDrdy = dataReady; prevTrack = trackEn; latched = '0;
    while (checked < NCODES) begin
      @(negedge clk);
      res = {dataHi, dataLo};
      if (dataReady && !prevDrdy) begin
        check("R5 result equals input", res, expVin);
        checked++;
        if (fullWin) begin
          check("R2 cycle length", sinceRise, 15);
          check("R3 track clocks", trackCnt, 3);
          check("R7 ready clocks", drdyCnt, 1);
        end
        fullWin = 1'b1; sinceRise = 0; trackCnt = 0; drdyCnt = 0; latched = res;
        if (checked == NCODES) begin
          vin = 12'hA5C;
          startN = 1'b1;
        end else begin
          vin = codeAt(nextIdx);
          nextIdx++;
        end
        expVin = vin;
      end else begin
        if (fullWin) check("R6 result held", res, latched);
        if (!trackEn && prevTrack) check("R4 first trial", trialCode, 12'h800);
      end
      sinceRise++;
      trackCnt += int'(trackEn);
      drdyCnt  += int'(dataReady);
      prevDrdy = dataReady;
      prevTrack = trackEn;
    end

    // Triggered mode: one more cycle, then halt
    gotRise = 1'b0;
    for (int i = 0; i < 20 && !gotRise; i++) begin
      @(negedge clk);
      if (dataReady && !prevDrdy) gotRise = 1'b1;
      prevDrdy = dataReady;
    end
    check("R8 final cycle completes", gotRise, 1);
    check("R5 final result", {dataHi, dataLo}, 12'hA5C);
    repeat (4) @(negedge clk);
    check("R8 halted", clkRunning, 0);
    check("R8 ready held", dataReady, 1);
    check("R8 tracking while halted", trackEn, 1);

    // R11 three-state bus
    pullVal = 1'b1; hiEnN = 1'b1; #1;
    check("R11 hi released pull1", dataHi, 8'hFF);
    check("R11 lo driven", dataLo, 4'hC);
    pullVal = 1'b0; #1;
    check("R11 hi released pull0", dataHi, 8'h00);
    hiEnN = 1'b0; loEnN = 1'b1; #1;
    check("R11 hi driven", dataHi, 8'hA5);
    check("R11 lo released pull0", dataLo, 4'h0);
    pullVal = 1'b1; #1;
    check("R11 lo released pull1", dataLo, 4'hF);
    loEnN = 1'b0; pullVal = 1'b0;

    // Short start pulse restarts one conversion
    @(negedge clk);
    vin = 12'h3C1;
    startN = 1'b0;
    repeat (2) @(negedge clk);
    startN = 1'b1;
    gotRise = 1'b0;
    prevDrdy = dataReady;
    for (int i = 0; i < 25 && !gotRise; i++) begin
      @(negedge clk);
      if (dataReady && !prevDrdy) gotRise = 1'b1;
      prevDrdy = dataReady;
    end
    check("R9 pulse restarts", gotRise, 1);
    check("R5 triggered result", {dataHi, dataLo}, 12'h3C1);
    repeat (4) @(negedge clk);
    check("R8 halted again", clkRunning, 0);

    if (!done) begin
      done = 1'b1;
      finishRun();
    end
  end
endmodule